// File: doc/BRIEF.md
# Muteable Serial Receiver with Address and Idle Wake-up

This block receives asynchronous serial characters from one input line. The line is sampled on a 16x oversampling tick that the caller supplies. Each character has a low start bit, DATA_W data bits sent least significant bit first, and a high stop bit. Every accepted character goes into a data register. Three status flags report the character: a ready flag, a framing-error flag and a line-idle flag. The receive interrupt output is the ready flag and the idle flag, each gated by its own enable bit and ORed together. Software clears the flags by reading the status register and then reading the data register.

On a bus shared by several receivers, software can put the block to sleep by setting the mute control bit. While the block is muted, no flag is set, the data register is left unchanged and the interrupt stays low. A wake-select bit chooses how the block wakes up. With the bit clear, a full idle character time on the line wakes the block, and the idle flag is not set for that period. With the bit set, the block wakes on a character whose most significant bit is 1. That character is stored and flagged like any normal character. A control write always loads the mute bit. A write made after a wake-up, using a value read before the wake-up, therefore mutes the block again, and the address character is lost.

Top module: `uart_rx_mute`

## Requirements
- R1: The start bit is checked at the 8th tick after the line is first seen low. Each data bit is then sampled 16 ticks after the previous sample, least significant bit first, and the stop bit is sampled in the same way. A complete character loads `data_q` and sets the ready flag. The status encoding is: `stat_q[0]` = ready, `stat_q[1]` = framing error, `stat_q[2]` = idle.
- R2: If the line is low for fewer than 8 ticks, the low pulse is discarded and no flag is set.
- R3: If the stop bit is sampled low, the framing-error flag is set together with the ready flag, and the character is still loaded into `data_q`.
- R4: A break (the line held low) produces one all-zero character with a framing error. After that, no further character is received until the line has been high.
- R5: When the line has been high for (DATA_W+2)*16 ticks in a row, the idle flag is set. It is set once per high stretch; a low level on the line re-arms it.
- R6: A pulse on `data_rd` clears only the flags that were set when the most recent `stat_rd` pulse occurred. A `data_rd` pulse with no earlier `stat_rd` pulse clears nothing.
- R7: `irq` equals (ready AND ready-interrupt enable) OR (idle AND idle-interrupt enable), and is 0 while muted. The control bits are: `ctrl_wdata[0]` = mute, `[1]` = wake on address, `[2]` = ready-interrupt enable, `[3]` = idle-interrupt enable.
- R8: While muted, no flag is set and `data_q` does not change.
- R9: If the block is muted with wake-on-address clear, an idle period clears `muted` and leaves the idle flag clear.
- R10: If the block is muted with wake-on-address set, a character whose most significant bit is 1 clears `muted`, sets the ready flag and loads `data_q`. Characters with a most significant bit of 0, and idle periods, are ignored.
- R11: Every control write loads the mute bit from `ctrl_wdata[0]`. A write of 1 after an address wake-up mutes the block again.
- R12: After reset, all flags, `data_q`, `muted` and `irq` are 0.
- R13: The receiver counts time only on cycles where `tick16` is high, so a slower tick rate stretches the bit period to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Serial input line, high when idle |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control value: mute, wake on address, ready-interrupt enable, idle-interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| stat_q | output | 3 | Flags: idle, framing error, ready |
| data_q | output | DATA_W | Last accepted character |
| muted | output | 1 | Current mute state |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach from the ports is the re-mute race. An address character has to wake the block, and a control write that still carries the mute bit has to land after that wake-up and before software has serviced the character. The bench builds this case directly: it mutes the block with wake-on-address set, sends a character whose top bit is 1, checks that the block woke, and then repeats the control write. It then checks that the block is muted again and that the next character does not replace the stored data. Idle wake-up needs an idle detector that has been re-armed beforehand. The bench therefore sends characters after muting, which drives the line low, and only then lets the line rest for a full character time. Random characters at varying tick rates, some with a bad stop bit, cover the main framing path.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_WAIT_START,
    RX_CHECK_START,
    RX_SHIFT,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  localparam int FLG_READY = 0;
  localparam int FLG_FRAME = 1;
  localparam int FLG_IDLE  = 2;
  localparam int FLG_W     = 3;

  localparam int CTL_MUTE  = 0;
  localparam int CTL_WADDR = 1;
  localparam int CTL_RIE   = 2;
  localparam int CTL_IIE   = 3;
  localparam int CTL_W     = 4;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= 1'b1;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              stop_ok
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] TOP_C  = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_WAIT_START;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      done    <= 1'b0;
      word    <= '0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_WAIT_START: begin
            cnt <= '0;
            if (!line) state <= RX_CHECK_START;
          end
          RX_CHECK_START: begin
            if (cnt == MID_C) begin
              cnt  <= '0;
              bitn <= '0;
              state <= line ? RX_WAIT_START : RX_SHIFT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_SHIFT: begin
            if (cnt == LAST_C) begin
              cnt <= '0;
              sh  <= {line, sh[DATA_W-1:1]};
              if (bitn == TOP_C) state <= RX_STOP;
              else               bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST_C) begin
              cnt     <= '0;
              done    <= 1'b1;
              word    <= sh;
              stop_ok <= line;
              state   <= line ? RX_WAIT_START : RX_WAIT_HIGH;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_WAIT_HIGH: begin
            if (line) state <= RX_WAIT_START;
          end
          default: state <= RX_WAIT_START;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  output logic idle_hit
);
  localparam int IDLE_TICKS = (DATA_W + 2) * OVS;
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam logic [IW-1:0] END_C = IW'(IDLE_TICKS - 1);

  logic [IW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      fired    <= 1'b0;
      idle_hit <= 1'b0;
    end else begin
      idle_hit <= 1'b0;
      if (!line) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (cnt == END_C) begin
          cnt      <= '0;
          fired    <= 1'b1;
          idle_hit <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_flag_ctl.sv
module rx_flag_ctl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_word,
  input  logic              frame_stop_ok,
  input  logic              idle_hit,
  input  logic              ctrl_we,
  input  logic [CTL_W-1:0]  ctrl_wdata,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [FLG_W-1:0]  flags_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              mute_q,
  output logic              irq_q
);
  logic [FLG_W-1:0] snap_q, set_v, clr_v, flags_n;
  logic waddr_q, rie_q, iie_q;
  logic waddr_n, rie_n, iie_n, mute_n, accept, irq_n;

  always_comb begin
    waddr_n = waddr_q;
    rie_n   = rie_q;
    iie_n   = iie_q;
    mute_n  = mute_q;
    set_v   = '0;
    clr_v   = data_rd ? snap_q : '0;
    accept  = frame_done && (!mute_q || (waddr_q && frame_word[DATA_W-1]));
    if (accept) begin
      set_v[FLG_READY] = 1'b1;
      set_v[FLG_FRAME] = !frame_stop_ok;
      mute_n           = 1'b0;
    end
    if (idle_hit) begin
      if (!mute_q)       set_v[FLG_IDLE] = 1'b1;
      else if (!waddr_q) mute_n = 1'b0;
    end
    if (ctrl_we) begin
      mute_n  = ctrl_wdata[CTL_MUTE];
      waddr_n = ctrl_wdata[CTL_WADDR];
      rie_n   = ctrl_wdata[CTL_RIE];
      iie_n   = ctrl_wdata[CTL_IIE];
    end
    flags_n = (flags_q & ~clr_v) | set_v;
    irq_n   = !mute_n && ((flags_n[FLG_READY] && rie_n) || (flags_n[FLG_IDLE] && iie_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
      mute_q  <= 1'b0;
      waddr_q <= 1'b0;
      rie_q   <= 1'b0;
      iie_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      mute_q  <= mute_n;
      waddr_q <= waddr_n;
      rie_q   <= rie_n;
      iie_q   <= iie_n;
      irq_q   <= irq_n;
      if (accept)       rdata_q <= frame_word;
      if (stat_rd)      snap_q  <= flags_q;
      else if (data_rd) snap_q  <= '0;
    end
  end
endmodule

// File: rtl/uart_rx_mute.sv
module uart_rx_mute
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              ctrl_we,
  input  logic [3:0]        ctrl_wdata,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [2:0]        stat_q,
  output logic [DATA_W-1:0] data_q,
  output logic              muted,
  output logic              irq
);
  logic              line_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_word;
  logic              frame_stop_ok;
  logic              idle_hit;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(line_s)
  );

  rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s),
    .done(frame_done), .word(frame_word), .stop_ok(frame_stop_ok)
  );

  rx_idle_det #(.DATA_W(DATA_W), .OVS(OVS)) u_idle (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s), .idle_hit(idle_hit)
  );

  rx_flag_ctl #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst),
    .frame_done(frame_done), .frame_word(frame_word), .frame_stop_ok(frame_stop_ok),
    .idle_hit(idle_hit),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .data_rd(data_rd),
    .flags_q(stat_q), .rdata_q(data_q), .mute_q(muted), .irq_q(irq)
  );
endmodule

// File: rtl/uart_rx_mute_chk.sv
module uart_rx_mute_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              muted,
  input logic              irq,
  input logic [2:0]        stat_q,
  input logic [DATA_W-1:0] data_q,
  input logic              data_rd,
  input logic              ctrl_we,
  input logic              frame_done,
  input logic              idle_hit
);
  // R7
  mute_irq_chk: assert property (@(posedge clk) disable iff (rst)
    muted |-> !irq);

  // R3
  fe_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[1]) |-> stat_q[0]);

  // R8
  mute_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (muted && $past(muted) && !$past(ctrl_we)) |-> !($rose(stat_q[0]) || $rose(stat_q[2])));

  // R6
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[0]) |-> $past(data_rd));

  // R1
  data_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q) |-> (stat_q[0] && $past(frame_done)));

  // R5
  idle_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[2]) |-> $past(idle_hit));
endmodule

bind uart_rx_mute uart_rx_mute_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .muted(muted), .irq(irq), .stat_q(stat_q),
  .data_q(data_q), .data_rd(data_rd), .ctrl_we(ctrl_we),
  .frame_done(frame_done), .idle_hit(idle_hit)
);

// File: tb/sim_uart_rx_mute.sv
`timescale 1ns/1ps
module sim_uart_rx_mute;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = 4'h0;
  logic stat_rd = 1'b0;
  logic data_rd = 1'b0;
  logic [2:0] stat_q;
  logic [DW-1:0] data_q;
  logic muted, irq;

  int n_chk = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (tcnt >= tick_div - 1) begin
      tick16 <= 1'b1;
      tcnt   <= 0;
    end else begin
      tick16 <= 1'b0;
      tcnt   <= tcnt + 1;
    end
  end

  uart_rx_mute #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .data_rd(data_rd),
    .stat_q(stat_q), .data_q(data_q), .muted(muted), .irq(irq)
  );

  function automatic int exp_stat(bit bad_stop);
    return bad_stop ? 3 : 1;
  endfunction

  function automatic int exp_irq(int st, bit rie, bit iie, bit mu);
    return (!mu && (((st & 1) != 0 && rie) || ((st & 4) != 0 && iie))) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic send_frame(logic [DW-1:0] b, bit stop_bit);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < DW; i++) begin
      rxd = b[i];
      wait_ticks(16);
    end
    rxd = stop_bit;
    wait_ticks(16);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ctrl_write(logic [3:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_clear();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    wait_ticks(175);
    read_clear();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 stat", stat_q, 0);
    chk("R12 data", data_q, 0);
    chk("R12 muted", muted, 0);
    chk("R12 irq", irq, 0);

    // R5 idle after a full character time of high line
    wait_ticks(175);
    chk("R5 idle set", stat_q, 4);
    chk("R7 idle irq disabled", irq, 0);
    ctrl_write(4'b1000);
    chk("R7 idle irq enabled", irq, 1);
    read_clear();
    chk("R6 idle cleared", stat_q, 0);
    chk("R7 irq drops", irq, 0);
    wait_ticks(200);
    chk("R5 once per high stretch", stat_q, 0);

    // R1 normal character
    ctrl_write(4'b0100);
    send_frame(8'hA5, 1'b1);
    chk("R1 stat", stat_q, exp_stat(0));
    chk("R1 data", data_q, 8'hA5);
    chk("R7 ready irq", irq, exp_irq(stat_q, 1, 0, 0));
    @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
    chk("R6 data read alone", stat_q, 1);
    read_clear();
    chk("R6 cleared", stat_q, 0);
    // R6 snapshot: status read before the character arrives
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    send_frame(8'h5A, 1'b1);
    @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
    chk("R6 unseen flag kept", stat_q, 1);
    read_clear();

    // R2 short low glitch
    rxd = 1'b0; wait_ticks(5); rxd = 1'b1;
    wait_ticks(30);
    chk("R2 glitch ignored", stat_q, 0);
    send_frame(8'h3C, 1'b1);
    chk("R2 next frame ok", data_q, 8'h3C);
    read_clear();

    // R3 bad stop bit
    send_frame(8'h81, 1'b0);
    chk("R3 stat", stat_q, exp_stat(1));
    chk("R3 data", data_q, 8'h81);
    chk("R3 irq", irq, 1);
    read_clear();
    chk("R3 cleared", stat_q, 0);

    // R4 break
    rxd = 1'b0;
    wait_ticks(16 * 25);
    chk("R4 break stat", stat_q, 3);
    chk("R4 break data", data_q, 0);
    read_clear();
    wait_ticks(16 * 12);
    chk("R4 no more while low", stat_q, 0);
    rxd = 1'b1;
    settle();

    // R9 idle wake-up
    ctrl_write(4'b0101);
    chk("R11 mute set", muted, 1);
    chk("R7 irq low muted", irq, 0);
    send_frame(8'h12, 1'b1);
    send_frame(8'h93, 1'b1);
    chk("R8 no flags muted", stat_q, 0);
    chk("R8 data kept", data_q, 0);
    chk("R8 still muted", muted, 1);
    wait_ticks(175);
    chk("R9 woke", muted, 0);
    chk("R9 idle not set", stat_q, 0);

    // R10 address-mark wake-up
    ctrl_write(4'b0111);
    send_frame(8'h45, 1'b1);
    chk("R10 msb0 ignored", stat_q, 0);
    chk("R10 msb0 muted", muted, 1);
    wait_ticks(200);
    chk("R10 idle ignored", muted, 1);
    chk("R8 idle flag not set", stat_q, 0);
    send_frame(8'hC7, 1'b1);
    chk("R10 stat", stat_q, 1);
    chk("R10 data", data_q, 8'hC7);
    chk("R10 awake", muted, 0);
    chk("R7 irq after wake", irq, 1);
    read_clear();

    // R11 stale control write re-mutes
    ctrl_write(4'b0111);
    send_frame(8'h80, 1'b1);
    chk("R11 woke", muted, 0);
    ctrl_write(4'b0111);
    chk("R11 re-muted", muted, 1);
    chk("R11 irq low", irq, 0);
    send_frame(8'h11, 1'b1);
    chk("R11 data unchanged", data_q, 8'h80);
    ctrl_write(4'b0100);
    chk("R11 unmuted by write", muted, 0);
    read_clear();

    // R13 slower tick rate
    tick_div = 3;
    send_frame(8'h6B, 1'b1);
    chk("R13 data", data_q, 8'h6B);
    chk("R13 stat", stat_q, 1);
    read_clear();

    // R1 R3 random characters
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] b;
      bit bad;
      tick_div = 1 + int'($urandom % 3);
      b = DW'($urandom);
      bad = (($urandom % 4) == 0);
      send_frame(b, !bad);
      chk("R1 rand data", data_q, b);
      chk("R3 rand stat", stat_q, exp_stat(bad));
      chk("R7 rand irq", irq, exp_irq(stat_q, 1, 0, 0));
      read_clear();
      if (bad) wait_ticks(2);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule